// File: doc/BRIEF.md
# Single-Cycle Ones' Complement Adder

This block adds two 16-bit words in ones' complement arithmetic, the arithmetic behind the Internet-style checksum. The carry out of the top bit is added back into the bottom bit, which is called the end-around carry. The result comes out in one clock cycle, with no second addition stage and no carry fed back through a loop.

The block uses a single adder of twice the operand width. The two operands are joined into one double-width word, and the same operands in the opposite order form the second addend. The low half of that sum carries straight into the high half, so the high half already holds the folded result. An all-ones result (negative zero) is passed out as it is.

A parameter selects the output form. The sum can go straight through as combinational logic, or it can be captured in a register together with a valid flag. In the registered form, the register loads only on cycles where the input is marked valid.

Top module: `oc_adder`

## Requirements
- R1: When opa + opb, taken as unsigned integers, is below 2^16, `sum` equals opa + opb.
- R2: When opa + opb is 2^16 or more, `sum` equals opa + opb - 2^16 + 1 (the end-around carry). For example, 0x8000 + 0x8000 gives 0x0001 and 0xFFFF + 0x0001 gives 0x0001.
- R3: An all-ones result is never turned into zero. 0xFFFF + 0x0000 gives 0xFFFF, 0xFFFF + 0xFFFF gives 0xFFFF, and any operand pair with opb equal to the bitwise inverse of opa gives 0xFFFF.
- R4: The result does not depend on operand order: swapping opa and opb gives the same `sum`.
- R5: With STAGE = STAGE_FLOP (the default), `sum` and `out_valid` show the result of the operands presented with `in_valid` high exactly one rising clock edge later, and `out_valid` is `in_valid` delayed by one cycle.
- R6: With STAGE = STAGE_FLOP, while `rst_n` is low, `sum` reads 0x0000 and `out_valid` reads 0.
- R7: With STAGE = STAGE_PASS, `sum` is the ones' complement sum of the current inputs in the same cycle, and `out_valid` equals `in_valid`.
- R8: With STAGE = STAGE_FLOP, a cycle with `in_valid` low leaves `sum` unchanged, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| opa | input | OPW (16) | First operand |
| opb | input | OPW (16) | Second operand |
| out_valid | output | 1 | Result valid |
| sum | output | OPW (16) | Ones' complement sum |

## Verification
The corner pairs are chosen to separate the two paths through the arithmetic:
- 0x0000 + 0x0000 tells zero apart from negative zero.
- 0xFFFF + 0x0000 and operand pairs that are bitwise inverses must keep all-ones with no carry.
- 0xFFFF + 0xFFFF and 0x8000 + 0x8000 exercise the end-around carry, once landing on all-ones and once landing on 0x0001.

Sums just below and just above 2^16 locate the carry boundary. Random operands, each followed by the same pair in swapped order, cover the general case and order independence. Idle cycles with changing operands show that the registered output holds. A second, combinational instance shows the same arithmetic with no added latency.

// File: rtl/oc_pkg.sv
package oc_pkg;
  // Output stage variant selected by the top-level parameter
  typedef enum logic [0:0] {
    STAGE_PASS = 1'b0,
    STAGE_FLOP = 1'b1
  } stage_e;
endpackage

// File: rtl/oc_swap_adder.sv
// One double-width addition of swapped operand pairs; the carry out of
// the low half lands in the high half, which is the folded result.
module oc_swap_adder #(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [OPW-1:0] folded,
  output logic [OPW-1:0] low_half,
  output logic           end_carry
);
  localparam int unsigned WW = 2 * OPW;

  logic [WW-1:0] addend_ab;
  logic [WW-1:0] addend_ba;
  logic [WW-1:0] wide;

  assign addend_ab = {a, b};
  assign addend_ba = {b, a};
  assign wide      = addend_ab + addend_ba;

  assign folded    = wide[WW-1:OPW];
  assign low_half  = wide[OPW-1:0];
  // carry entering the high half, recovered from its bit zero
  assign end_carry = wide[OPW] ^ a[0] ^ b[0];
endmodule

// File: rtl/oc_out_stage.sv
module oc_out_stage #(
  parameter int unsigned   OPW   = 16,
  parameter oc_pkg::stage_e STAGE = oc_pkg::STAGE_FLOP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] d,
  output logic           out_valid,
  output logic [OPW-1:0] q
);
  generate
    if (STAGE == oc_pkg::STAGE_FLOP) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          q         <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) q <= d;
        end
      end
    end else begin : g_pass
      assign out_valid = in_valid;
      assign q         = d;
    end
  endgenerate
endmodule

// File: rtl/oc_adder.sv
module oc_adder #(
  parameter int unsigned    OPW   = 16,
  parameter oc_pkg::stage_e STAGE = oc_pkg::STAGE_FLOP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  output logic           out_valid,
  output logic [OPW-1:0] sum
);
  // named internal events for the checker
  logic [OPW-1:0] comb_sum;
  logic [OPW-1:0] low_half;
  logic           end_carry;

  oc_swap_adder #(.OPW(OPW)) u_add (
    .a         (opa),
    .b         (opb),
    .folded    (comb_sum),
    .low_half  (low_half),
    .end_carry (end_carry)
  );

  oc_out_stage #(.OPW(OPW), .STAGE(STAGE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d         (comb_sum),
    .out_valid (out_valid),
    .q         (sum)
  );
endmodule

// File: rtl/oc_adder_chk.sv
module oc_adder_chk #(
  parameter int unsigned    OPW   = 16,
  parameter oc_pkg::stage_e STAGE = oc_pkg::STAGE_FLOP
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [OPW-1:0] opa,
  input logic [OPW-1:0] opb,
  input logic           out_valid,
  input logic [OPW-1:0] sum,
  input logic [OPW-1:0] comb_sum,
  input logic [OPW-1:0] low_half,
  input logic           end_carry
);
  // reference: narrow add with explicit carry, then a second add
  logic [OPW:0]   plain;
  logic [OPW-1:0] ref_sum;
  assign plain   = {1'b0, opa} + {1'b0, opb};
  assign ref_sum = plain[OPW-1:0] + {{(OPW-1){1'b0}}, plain[OPW]};

  // R2
  carry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_carry == plain[OPW]);

  // R1
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_half == plain[OPW-1:0]);

  // R1
  comb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_sum == ref_sum);

  // R3
  neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opb == ~opa) |-> (comb_sum == {OPW{1'b1}}));

  generate
    if (STAGE == oc_pkg::STAGE_FLOP) begin : g_flop_chk
      // R5
      valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R5
      valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R5
      late_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sum == $past(ref_sum)));
      // R8
      hold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum));
    end else begin : g_pass_chk
      // R7
      pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
    end
  endgenerate
endmodule

bind oc_adder oc_adder_chk #(.OPW(OPW), .STAGE(STAGE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .opa       (opa),
  .opb       (opb),
  .out_valid (out_valid),
  .sum       (sum),
  .comb_sum  (comb_sum),
  .low_half  (low_half),
  .end_carry (end_carry)
);

// File: tb/sim_oc_adder.sv
`timescale 1ns/1ps
module sim_oc_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic        out_valid;
  logic [15:0] sum;
  logic        c_valid;
  logic [15:0] c_sum;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_exp = '0;

  always #2.5 clk = ~clk;

  oc_adder #(.OPW(16), .STAGE(oc_pkg::STAGE_FLOP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .out_valid(out_valid), .sum(sum));

  oc_adder #(.OPW(16), .STAGE(oc_pkg::STAGE_PASS)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .out_valid(c_valid), .sum(c_sum));

  // model: subtract the modulus 65535 once if the plain sum exceeds it
  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
    int t;
    t = int'(a) + int'(b);
    if (t > 65535) t = t - 65535;
    return t[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input string req);
    @(negedge clk);
    opa = a; opb = b; in_valid = 1'b1;
    exp_q.push_back(model(a, b));
    tag_q.push_back(req);
    last_exp = model(a, b);
    #0.5;
    check({req, " R7 comb"}, {16'h0, c_sum}, {16'h0, model(a, b)});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = 16'($urandom); opb = 16'($urandom);
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected valid", 32'd1, 32'd0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {16'h0, sum}, {16'h0, e});
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    check("R6 sum in reset", {16'h0, sum}, 32'h0);
    check("R6 valid in reset", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R6 sum after reset", {16'h0, sum}, 32'h0);

    // corner cases
    drive(16'h0000, 16'h0000, "R1 zero");
    drive(16'hFFFF, 16'h0000, "R3 ffff+0");
    drive(16'hFFFF, 16'hFFFF, "R3 ffff+ffff");
    drive(16'h8000, 16'h8000, "R2 8000+8000");
    drive(16'hFFFF, 16'h0001, "R2 ffff+1");
    drive(16'hFFFE, 16'h0001, "R3 fffe+1");
    drive(16'h1234, 16'hEDCB, "R3 inverse pair");
    drive(16'h7FFF, 16'h8000, "R1 just below");
    drive(16'h8001, 16'h8000, "R2 just above");
    drive(16'h0102, 16'h0304, "R1 small");

    // R5 latency: one edge after presentation
    @(negedge clk);
    in_valid = 1'b1; opa = 16'hA000; opb = 16'h7000;
    exp_q.push_back(model(16'hA000, 16'h7000)); tag_q.push_back("R5 latency");
    last_exp = model(16'hA000, 16'h7000);
    @(posedge clk); #1;
    check("R5 valid one edge later", {31'h0, out_valid}, 32'h1);

    // R8 hold across idle cycles
    idle(1);
    @(posedge clk); #1.2;
    check("R5 valid drops", {31'h0, out_valid}, 32'h0);
    check("R8 hold", {16'h0, sum}, {16'h0, last_exp});
    idle(3);
    @(posedge clk); #1.2;
    check("R8 hold after idles", {16'h0, sum}, {16'h0, last_exp});
    check("R7 pass valid low", {31'h0, c_valid}, 32'h0);

    // random and swapped pairs
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom); b = 16'($urandom);
      drive(a, b, "R1 R2 random");
      drive(b, a, "R4 swapped");
      if (i % 37 == 0) idle(2);
    end
    idle(3);
    @(posedge clk); #1.2;
    check("R5 queue drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule